// File: doc/BRIEF.md
# Watermark-Gated Shared Pool Allocator

This block keeps a running count of how many entries of one shared pool (for example a load or store queue) each hardware thread holds. It decides whether each thread's allocation request may go ahead. It uses a high and a low watermark with hysteresis, so that a single thread cannot hold on to the pool. The pool is shared out again every cycle from the current counts. The threads do no handshaking with one another.

Each thread sends an allocation request with an entry count, and a release pulse with an entry count. The block returns a grant for each thread in the same cycle as the request. The updated per-thread occupancy and the stall flags appear on the next clock edge.

A thread whose granted allocation takes it to the high watermark becomes stalled. Further requests from that thread are refused until releases bring it down to the low watermark. A request that would push the whole pool past its capacity is also refused, even when the thread is below its high mark. Both watermarks sit in registers that can be rewritten while no thread is allocating or releasing.

Top module: `alloc_wm_gate`

## Requirements
- R1: After reset every occupancy count is 0, every stall flag is 0, and the watermark outputs show HI_RST (12) and LO_RST (4).
- R2: A granted request raises that thread's occupancy by its count on the next clock edge. A request that is not granted leaves the occupancy unchanged.
- R3: The sum of all occupancies never exceeds POOL (32). A request that would take the total above POOL is refused even when the thread is below its high mark. Requests are considered in ascending thread order, and a refused request uses up no capacity.
- R4: When a granted request brings a thread's updated occupancy to the high watermark or above, that thread's stall flag is 1 after the next clock edge.
- R5: While a thread's stall flag is 1, its grant is 0 and its requests do not change its occupancy.
- R6: A stalled thread's flag clears on the edge where a release brings its updated occupancy to the low watermark or below. A release that leaves it above the low mark keeps the flag set.
- R7: An allocation and a release for the same thread in the same cycle change its occupancy by the net amount, and the watermark checks use that net value.
- R8: A watermark write takes effect on the next edge only when the new low value is strictly below the new high value and no allocation or release pulse is active in that cycle. Any other write is ignored.
- R9: A stall on one thread does not affect the grants of other threads.
- R10: A release larger than the thread's occupancy leaves that occupancy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | THREADS | Allocation request, one bit per thread |
| alloc_cnt | input | THREADS*CW | Entries requested, CW bits per thread, thread 0 in the low bits |
| free_vld | input | THREADS | Release pulse, one bit per thread |
| free_cnt | input | THREADS*CW | Entries released, CW bits per thread |
| wm_we | input | 1 | Watermark write strobe |
| wm_hi_in | input | OW | New high watermark |
| wm_lo_in | input | OW | New low watermark |
| alloc_gnt | output | THREADS | Request accepted this cycle (combinational) |
| stall | output | THREADS | Per-thread stall flag |
| occ | output | THREADS*OW | Per-thread occupancy, OW bits per thread |
| wm_hi | output | OW | Current high watermark |
| wm_lo | output | OW | Current low watermark |

## Verification
Grants are combinational, so they are sampled one time unit after the inputs are driven on the falling edge, in the same cycle as the request. Occupancy, stall flags and watermarks are each one register deep. They are therefore checked on the falling edge after the next rising edge, once the request and release pulses have been removed. Each scenario task drives a single cycle of stimulus and checks both points before it moves on, so that no result is sampled a cycle early or late.

// File: rtl/alloc_wm_pkg.sv
package alloc_wm_pkg;
    localparam int THREADS = 8;
    localparam int POOL    = 32;
    localparam int CW      = 4;
    localparam int OW      = $clog2(POOL + 1);
    localparam int SW      = OW + CW + $clog2(THREADS) + 1;

    typedef struct packed {
        logic [OW-1:0] occ;
        logic          stall;
    } thr_state_t;

    typedef struct packed {
        logic [OW-1:0] hi;
        logic [OW-1:0] lo;
    } wm_state_t;
endpackage

// File: rtl/alloc_wm_cfg.sv
module alloc_wm_cfg
    import alloc_wm_pkg::*;
#(
    parameter int HI_RST = 12,
    parameter int LO_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          busy,
    input  logic [OW-1:0] hi_in,
    input  logic [OW-1:0] lo_in,
    output logic [OW-1:0] hi,
    output logic [OW-1:0] lo
);
    wm_state_t wm_d, wm_q;

    always_comb begin
        wm_d = wm_q;
        if (we && !busy && (lo_in < hi_in)) begin
            wm_d.hi = hi_in;
            wm_d.lo = lo_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q.hi <= OW'(HI_RST);
            wm_q.lo <= OW'(LO_RST);
        end else begin
            wm_q <= wm_d;
        end
    end

    assign hi = wm_q.hi;
    assign lo = wm_q.lo;

    // R8: the stored watermarks always keep low strictly under high
    assert_wm_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wm_q.lo < wm_q.hi);
    // R8: nothing changes while a pulse was active
    assert_wm_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wm_q));
endmodule

// File: rtl/alloc_wm_admit.sv
module alloc_wm_admit
    import alloc_wm_pkg::*;
(
    input  logic [THREADS-1:0]    req,
    input  logic [THREADS*CW-1:0] cnt,
    input  logic [THREADS-1:0]    stall,
    input  logic [SW-1:0]         total,
    output logic [THREADS-1:0]    gnt
);
    logic [SW-1:0] run [THREADS+1];

    assign run[0] = total;

    for (genvar t = 0; t < THREADS; t++) begin : g_chain
        logic [SW-1:0] want;
        assign want     = run[t] + SW'(cnt[t*CW +: CW]);
        assign gnt[t]   = req[t] && !stall[t] && (want <= SW'(POOL));
        assign run[t+1] = gnt[t] ? want : run[t];
    end
endmodule

// File: rtl/alloc_wm_thread.sv
module alloc_wm_thread
    import alloc_wm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt,
    input  logic [CW-1:0] acnt,
    input  logic          fvld,
    input  logic [CW-1:0] fcnt,
    input  logic [OW-1:0] hi,
    input  logic [OW-1:0] lo,
    output logic [OW-1:0] occ,
    output logic          stall
);
    thr_state_t st_d, st_q;
    logic [OW:0] sum;
    logic [OW:0] sub;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.occ} + (gnt ? (OW+1)'(acnt) : '0);
        sub  = fvld ? (OW+1)'(fcnt) : '0;
        st_d.occ = (sub >= sum) ? '0 : OW'(sum - sub);
        if (!st_q.stall && gnt && (st_d.occ >= hi))
            st_d.stall = 1'b1;
        else if (st_q.stall && fvld && (st_d.occ <= lo))
            st_d.stall = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ   = st_q.occ;
    assign stall = st_q.stall;

    // R5: a stalled thread never receives a grant
    assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stall |-> !gnt);
    // R2: without grant or release the count holds
    assert_occ_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt && !fvld) |=> $stable(st_q.occ));
    // R4: a new stall means the high mark was reached
    assert_stall_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.stall) |-> (st_q.occ >= $past(hi)));
    // R6: a stall ends only at or under the low mark
    assert_stall_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.stall) |-> (st_q.occ <= $past(lo)));
endmodule

// File: rtl/alloc_wm_gate.sv
module alloc_wm_gate
    import alloc_wm_pkg::*;
#(
    parameter int HI_RST = 12,
    parameter int LO_RST = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [THREADS-1:0]    alloc_req,
    input  logic [THREADS*CW-1:0] alloc_cnt,
    input  logic [THREADS-1:0]    free_vld,
    input  logic [THREADS*CW-1:0] free_cnt,
    input  logic                  wm_we,
    input  logic [OW-1:0]         wm_hi_in,
    input  logic [OW-1:0]         wm_lo_in,
    output logic [THREADS-1:0]    alloc_gnt,
    output logic [THREADS-1:0]    stall,
    output logic [THREADS*OW-1:0] occ,
    output logic [OW-1:0]         wm_hi,
    output logic [OW-1:0]         wm_lo
);
    logic [SW-1:0] total;
    logic          busy;

    assign busy = (|alloc_req) || (|free_vld);

    always_comb begin
        total = '0;
        for (int t = 0; t < THREADS; t++)
            total = total + SW'(occ[t*OW +: OW]);
    end

    alloc_wm_cfg #(.HI_RST(HI_RST), .LO_RST(LO_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(wm_we), .busy(busy),
        .hi_in(wm_hi_in), .lo_in(wm_lo_in), .hi(wm_hi), .lo(wm_lo)
    );

    alloc_wm_admit u_admit (
        .req(alloc_req), .cnt(alloc_cnt), .stall(stall),
        .total(total), .gnt(alloc_gnt)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        alloc_wm_thread u_thr (
            .clk(clk), .rst_n(rst_n), .gnt(alloc_gnt[t]),
            .acnt(alloc_cnt[t*CW +: CW]), .fvld(free_vld[t]),
            .fcnt(free_cnt[t*CW +: CW]), .hi(wm_hi), .lo(wm_lo),
            .occ(occ[t*OW +: OW]), .stall(stall[t])
        );
    end

    // R3: pool capacity is never exceeded
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        total <= SW'(POOL));
    // R3: grants are only given to requesters
    assert_gnt_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt & ~alloc_req) == '0);
endmodule

// File: tb/tb_alloc_wm_gate.sv
module tb_alloc_wm_gate;
    import alloc_wm_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [THREADS-1:0]    alloc_req = '0;
    logic [THREADS*CW-1:0] alloc_cnt = '0;
    logic [THREADS-1:0]    free_vld = '0;
    logic [THREADS*CW-1:0] free_cnt = '0;
    logic                  wm_we = 1'b0;
    logic [OW-1:0]         wm_hi_in = '0;
    logic [OW-1:0]         wm_lo_in = '0;
    logic [THREADS-1:0]    alloc_gnt;
    logic [THREADS-1:0]    stall;
    logic [THREADS*OW-1:0] occ;
    logic [OW-1:0]         wm_hi, wm_lo;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alloc_wm_gate dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int occ_of(input int t);
        return int'(occ[t*OW +: OW]);
    endfunction

    task automatic set_alloc(input int t, input int n);
        alloc_req[t] = 1'b1;
        alloc_cnt[t*CW +: CW] = CW'(n);
    endtask

    task automatic set_free(input int t, input int n);
        free_vld[t] = 1'b1;
        free_cnt[t*CW +: CW] = CW'(n);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        alloc_req = '0; alloc_cnt = '0; free_vld = '0; free_cnt = '0; wm_we = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        for (int t = 0; t < THREADS; t++) begin
            chk("R1 occ", occ_of(t), 0);
            chk("R1 stall", int'(stall[t]), 0);
        end
        chk("R1 hi", int'(wm_hi), 12);
        chk("R1 lo", int'(wm_lo), 4);
    endtask

    task automatic t_basic();
        set_alloc(0, 5); #1;
        chk("R2 grant", int'(alloc_gnt[0]), 1);
        step();
        chk("R2 occ0", occ_of(0), 5);
        chk("R2 no stall", int'(stall[0]), 0);
    endtask

    task automatic t_high();
        set_alloc(0, 7); #1;
        chk("R4 grant", int'(alloc_gnt[0]), 1);
        step();
        chk("R4 occ0", occ_of(0), 12);
        chk("R4 stall0", int'(stall[0]), 1);
        set_alloc(0, 1); set_alloc(1, 3); #1;
        chk("R5 refused", int'(alloc_gnt[0]), 0);
        chk("R9 other grant", int'(alloc_gnt[1]), 1);
        step();
        chk("R5 occ0 held", occ_of(0), 12);
        chk("R9 occ1", occ_of(1), 3);
        chk("R9 stall1", int'(stall[1]), 0);
    endtask

    task automatic t_low();
        set_free(0, 6); step();
        chk("R6 occ0", occ_of(0), 6);
        chk("R6 still stalled", int'(stall[0]), 1);
        set_free(0, 2); step();
        chk("R6 occ0 low", occ_of(0), 4);
        chk("R6 cleared", int'(stall[0]), 0);
    endtask

    task automatic t_net();
        set_alloc(1, 10); set_free(1, 1); #1;
        chk("R7 grant", int'(alloc_gnt[1]), 1);
        step();
        chk("R7 net occ1", occ_of(1), 12);
        chk("R7 stall1", int'(stall[1]), 1);
        set_alloc(1, 2); set_free(1, 8); step();
        chk("R7 net release", occ_of(1), 4);
        chk("R7 cleared", int'(stall[1]), 0);
    endtask

    task automatic t_sat();
        set_free(2, 5); step();
        chk("R10 occ2", occ_of(2), 0);
    endtask

    task automatic t_pool();
        set_alloc(2, 11); set_alloc(3, 11); step();
        chk("R3 occ2", occ_of(2), 11);
        chk("R3 occ3", occ_of(3), 11);
        set_alloc(4, 3); set_alloc(5, 2); #1;
        chk("R3 overflow refused", int'(alloc_gnt[4]), 0);
        chk("R3 fitting granted", int'(alloc_gnt[5]), 1);
        step();
        chk("R3 occ4", occ_of(4), 0);
        chk("R3 occ5", occ_of(5), 2);
        set_free(2, 11); set_free(3, 11); set_free(5, 2); step();
        set_alloc(6, 11); set_alloc(7, 11); set_alloc(2, 11); #1;
        chk("R3 first", int'(alloc_gnt[2]), 1);
        chk("R3 second", int'(alloc_gnt[6]), 1);
        chk("R3 order refused", int'(alloc_gnt[7]), 0);
        step();
        chk("R3 occ7", occ_of(7), 0);
    endtask

    task automatic t_cfg();
        wm_we = 1'b1; wm_hi_in = 6'd20; wm_lo_in = 6'd20; step();
        chk("R8 bad order hi", int'(wm_hi), 12);
        chk("R8 bad order lo", int'(wm_lo), 4);
        wm_we = 1'b1; wm_hi_in = 6'd20; wm_lo_in = 6'd8; set_free(2, 1); step();
        chk("R8 busy hi", int'(wm_hi), 12);
        wm_we = 1'b1; wm_hi_in = 6'd20; wm_lo_in = 6'd8; step();
        chk("R8 accepted hi", int'(wm_hi), 20);
        chk("R8 accepted lo", int'(wm_lo), 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_high();
        t_low();
        t_net();
        t_sat();
        t_pool();
        t_cfg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule